// File: doc/BRIEF.md
# Configuration Trapdoor Register Window

This block sits behind a byte-addressed host bus that normally reaches an eight-entry disk task-file window. Hidden behind the same offsets is a small bank of controller configuration registers: a read-cycle timing byte, a write-cycle timing byte, a control byte, a strap probe byte and a miscellaneous byte. These are only reachable after a fixed access pattern on the ordinary ports. The pattern is two back-to-back 16-bit reads of offset 1, then a byte write of 0x03 to offset 2. A byte write of 0x83 to offset 2 leaves the configuration mode again.

A sequence detector watches every bus access. While configuration mode is active, byte accesses are steered into the hidden bank, and the task file is left untouched. The read and write timing values that leave the block follow one of two default pairs, picked by a clock-strap input. This holds until software writes the completion code 0x85 to the control byte. From then on the programmed timings take over.

Top module: `cfg_trapdoor_window`

## Requirements
- R1: A synchronous active-high reset clears configuration mode, returns the sequence detector to idle, loads 0x00 into every configuration byte and every task-file word, and clears bus_rdata. The timing outputs then show the strap defaults.
- R2: Two consecutive 16-bit reads of offset 1, followed by an 8-bit write of 0x03 to offset 2, set cfg_active on the clock edge that takes the write. Cycles with neither strobe do not break the pattern.
- R3: Any access other than the exact next step of the pattern returns the detector to idle. Examples are an 8-bit read of offset 1, a read of another offset, a third 16-bit read, or any other write. cfg_active then stays 0 after a later 0x03 write to offset 2.
- R4: While configuration mode is active, an 8-bit write of 0x83 to offset 2 clears cfg_active. Any other write to offset 2 has no visible effect.
- R5: In configuration mode, 8-bit writes to offsets 0, 1, 3 and 6 load the read-timing, write-timing, control and miscellaneous bytes respectively. Reads of those offsets return the byte in bits 7:0 with the upper bits zero. Reads of offsets 2, 4 and 7 return 0.
- R6: In configuration mode, offset 5 holds a strap probe byte. While that byte is 0xFF, a read of offset 5 returns strap_in in bit 0 and zeros elsewhere. Otherwise the read returns the stored byte.
- R7: In configuration mode, 16-bit writes change no configuration byte.
- R8: While locked, each offset holds a 16-bit task-file word. A 16-bit write stores the whole word, and an 8-bit write replaces only bits 7:0. A 16-bit read returns the word, and an 8-bit read returns bits 7:0 zero-extended. Read data appears on bus_rdata one cycle after the read and holds until the next read.
- R9: Writes made while locked leave every configuration byte unchanged, including writes to offsets 0, 1, 3, 5 and 6 and to offset 2.
- R10: rd_timing_o and wr_timing_o show 0x6C and 0x5E when strap_in is 0, and 0x48 and 0x3D when strap_in is 1, as long as the control byte is not 0x85. When the control byte is 0x85, they show the programmed bytes. ctrl_o and misc_o always show their bytes. All four outputs are registered and settle within two cycles of the causing write.
- R11: No write made in configuration mode, and neither the unlocking 0x03 write nor the relocking 0x83 write, reaches the task file. A 0x03 write to offset 2 that does not complete the pattern is stored in the task file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Byte offset within the window |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, which takes precedence over bus_rd |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| bus_wdata | input | 16 | Write data; 8-bit writes use bits 7:0 |
| strap_in | input | 1 | Clock-speed strap, 1 = fast clock |
| bus_rdata | output | 16 | Registered read data |
| cfg_active | output | 1 | Configuration mode currently active |
| rd_timing_o | output | 8 | Effective read-cycle timing |
| wr_timing_o | output | 8 | Effective write-cycle timing |
| ctrl_o | output | 8 | Control byte |
| misc_o | output | 8 | Miscellaneous byte |

## Verification
The directed part exercises the complete unlock pattern with idle gaps, and then four broken variants: an 8-bit read in the middle, a read of a different offset, a third wide read, and a wrong magic value. Each variant shows whether the detector insists on the exact step order rather than just counting accesses. Locked and unlocked writes to the same offsets tell apart the two address decodes. Toggling the strap before and after the 0x85 completion code separates the default timing path from the programmed one. A seeded random run then mixes all access kinds with frequent full unlock and relock sequences, and compares every read and every mode change against a bench model.

// File: rtl/trapdoor_pkg.sv
package trapdoor_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ARM_IDLE = 2'd0,
    ARM_ONE  = 2'd1,
    ARM_TWO  = 2'd2
  } arm_state_e;

  // offsets that the sequence detector decodes
  localparam logic [2:0] OFS_ARM_PORT  = 3'd1;
  localparam logic [2:0] OFS_GATE_PORT = 3'd2;

  // hidden register offsets
  localparam logic [2:0] OFS_RD_TIME = 3'd0;
  localparam logic [2:0] OFS_WR_TIME = 3'd1;
  localparam logic [2:0] OFS_CTRL    = 3'd3;
  localparam logic [2:0] OFS_STRAP   = 3'd5;
  localparam logic [2:0] OFS_MISC    = 3'd6;

  localparam logic [BYTE_W-1:0] CODE_UNLOCK   = 8'h03;
  localparam logic [BYTE_W-1:0] CODE_RELOCK   = 8'h83;
  localparam logic [BYTE_W-1:0] CODE_OVERRIDE = 8'h85;
  localparam logic [BYTE_W-1:0] CODE_PROBE    = 8'hFF;

  typedef struct packed {
    logic [BYTE_W-1:0] rd_time;
    logic [BYTE_W-1:0] wr_time;
    logic [BYTE_W-1:0] ctrl;
    logic [BYTE_W-1:0] strap;
    logic [BYTE_W-1:0] misc;
  } cfg_bank_t;

endpackage

// File: rtl/unlock_seq.sv
module unlock_seq
  import trapdoor_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              wide,
  input  logic [BYTE_W-1:0] wbyte,
  output logic              cfg_mode,
  output logic              unlock_hit,
  output logic              relock_hit
);

  arm_state_e arm_q;
  logic       cfg_q;
  logic       rd_acc;
  logic       any_acc;
  logic       arm_read;
  logic       gate_write;

  assign rd_acc     = rd & ~wr;
  assign any_acc    = rd | wr;
  assign arm_read   = rd_acc & wide & (addr == ADDR_W'(OFS_ARM_PORT));
  assign gate_write = wr & ~wide & (addr == ADDR_W'(OFS_GATE_PORT));
  assign unlock_hit = ~cfg_q & (arm_q == ARM_TWO) & gate_write & (wbyte == CODE_UNLOCK);
  assign relock_hit = cfg_q & gate_write & (wbyte == CODE_RELOCK);
  assign cfg_mode   = cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= ARM_IDLE;
      cfg_q <= 1'b0;
    end else if (cfg_q) begin
      arm_q <= ARM_IDLE;
      if (relock_hit) cfg_q <= 1'b0;
    end else if (any_acc) begin
      unique case (arm_q)
        ARM_IDLE: arm_q <= arm_read ? ARM_ONE : ARM_IDLE;
        ARM_ONE:  arm_q <= arm_read ? ARM_TWO : ARM_IDLE;
        default:  arm_q <= ARM_IDLE;
      endcase
      if (unlock_hit) cfg_q <= 1'b1;
    end
  end

  assert_unlock_after_arm_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_q) |-> $past(arm_q) == ARM_TWO);

  assert_broken_step_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q && arm_q == ARM_ONE && any_acc && !arm_read) |=> arm_q == ARM_IDLE);

  assert_relock_code_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_q) |-> $past(wr && !wide && addr == ADDR_W'(OFS_GATE_PORT) && wbyte == CODE_RELOCK));

endmodule

// File: rtl/taskfile_regs.sv
module taskfile_regs
  import trapdoor_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rword
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] words_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        words_q[i] <= '0;
      end else if (wr_en && addr == ADDR_W'(i)) begin
        if (wide) words_q[i] <= wdata;
        else      words_q[i][BYTE_W-1:0] <= wdata[BYTE_W-1:0];
      end
    end
  end

  assign rword = words_q[addr];

  assert_tf_untouched_R11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(words_q));

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import trapdoor_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              wide,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              strap_in,
  output logic [BYTE_W-1:0] rbyte,
  output cfg_bank_t         bank
);

  cfg_bank_t bank_q;
  logic      byte_wr;

  assign byte_wr = cfg_mode & wr & ~wide;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
    end else if (byte_wr) begin
      case (addr)
        ADDR_W'(OFS_RD_TIME): bank_q.rd_time <= wbyte;
        ADDR_W'(OFS_WR_TIME): bank_q.wr_time <= wbyte;
        ADDR_W'(OFS_CTRL):    bank_q.ctrl    <= wbyte;
        ADDR_W'(OFS_STRAP):   bank_q.strap   <= wbyte;
        ADDR_W'(OFS_MISC):    bank_q.misc    <= wbyte;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(OFS_RD_TIME): rbyte = bank_q.rd_time;
      ADDR_W'(OFS_WR_TIME): rbyte = bank_q.wr_time;
      ADDR_W'(OFS_CTRL):    rbyte = bank_q.ctrl;
      ADDR_W'(OFS_STRAP):   rbyte = (bank_q.strap == CODE_PROBE) ?
                                    {{(BYTE_W-1){1'b0}}, strap_in} : bank_q.strap;
      ADDR_W'(OFS_MISC):    rbyte = bank_q.misc;
      default:              rbyte = '0;
    endcase
  end

  assign bank = bank_q;

  assert_locked_bank_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode |=> $stable(bank_q));

  assert_wide_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode && wr && wide) |=> $stable(bank_q));

endmodule

// File: rtl/timing_select.sv
module timing_select
  import trapdoor_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RD_SLOW = 8'h6C,
  parameter logic [BYTE_W-1:0] RD_FAST = 8'h48,
  parameter logic [BYTE_W-1:0] WR_SLOW = 8'h5E,
  parameter logic [BYTE_W-1:0] WR_FAST = 8'h3D
) (
  input  logic              clk,
  input  logic              rst,
  input  cfg_bank_t         bank,
  input  logic              strap_in,
  output logic [BYTE_W-1:0] rd_timing,
  output logic [BYTE_W-1:0] wr_timing,
  output logic [BYTE_W-1:0] ctrl,
  output logic [BYTE_W-1:0] misc
);

  logic              use_prog;
  logic [BYTE_W-1:0] rd_dflt;
  logic [BYTE_W-1:0] wr_dflt;

  assign use_prog = (bank.ctrl == CODE_OVERRIDE);
  assign rd_dflt  = strap_in ? RD_FAST : RD_SLOW;
  assign wr_dflt  = strap_in ? WR_FAST : WR_SLOW;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_timing <= RD_SLOW;
      wr_timing <= WR_SLOW;
      ctrl      <= '0;
      misc      <= '0;
    end else begin
      rd_timing <= use_prog ? bank.rd_time : rd_dflt;
      wr_timing <= use_prog ? bank.wr_time : wr_dflt;
      ctrl      <= bank.ctrl;
      misc      <= bank.misc;
    end
  end

  assert_override_follows_R10: assert property (@(posedge clk) disable iff (rst)
    $past(bank.ctrl) == CODE_OVERRIDE |-> rd_timing == $past(bank.rd_time) &&
                                          wr_timing == $past(bank.wr_time));

endmodule

// File: rtl/cfg_trapdoor_window.sv
module cfg_trapdoor_window
  import trapdoor_pkg::*;
#(
  parameter int                ADDR_W  = 3,
  parameter int                DATA_W  = 16,
  parameter logic [BYTE_W-1:0] RD_SLOW = 8'h6C,
  parameter logic [BYTE_W-1:0] RD_FAST = 8'h48,
  parameter logic [BYTE_W-1:0] WR_SLOW = 8'h5E,
  parameter logic [BYTE_W-1:0] WR_FAST = 8'h3D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_wide,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              strap_in,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cfg_active,
  output logic [BYTE_W-1:0] rd_timing_o,
  output logic [BYTE_W-1:0] wr_timing_o,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] misc_o
);

  localparam int PAD_W = DATA_W - BYTE_W;

  logic              cfg_mode;
  logic              unlock_hit;
  logic              relock_hit;
  logic              tf_wr_en;
  logic [DATA_W-1:0] tf_word;
  logic [BYTE_W-1:0] cfg_byte;
  logic              rd_acc;
  cfg_bank_t         bank;

  unlock_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .addr      (bus_addr),
    .rd        (bus_rd),
    .wr        (bus_wr),
    .wide      (bus_wide),
    .wbyte     (bus_wdata[BYTE_W-1:0]),
    .cfg_mode  (cfg_mode),
    .unlock_hit(unlock_hit),
    .relock_hit(relock_hit)
  );

  assign tf_wr_en = bus_wr & ~cfg_mode & ~unlock_hit;

  taskfile_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) tf_i (
    .clk  (clk),
    .rst  (rst),
    .wr_en(tf_wr_en),
    .addr (bus_addr),
    .wide (bus_wide),
    .wdata(bus_wdata),
    .rword(tf_word)
  );

  cfg_regbank #(.ADDR_W(ADDR_W)) bank_i (
    .clk     (clk),
    .rst     (rst),
    .cfg_mode(cfg_mode),
    .addr    (bus_addr),
    .wr      (bus_wr),
    .wide    (bus_wide),
    .wbyte   (bus_wdata[BYTE_W-1:0]),
    .strap_in(strap_in),
    .rbyte   (cfg_byte),
    .bank    (bank)
  );

  timing_select #(
    .RD_SLOW(RD_SLOW), .RD_FAST(RD_FAST),
    .WR_SLOW(WR_SLOW), .WR_FAST(WR_FAST)
  ) tsel_i (
    .clk      (clk),
    .rst      (rst),
    .bank     (bank),
    .strap_in (strap_in),
    .rd_timing(rd_timing_o),
    .wr_timing(wr_timing_o),
    .ctrl     (ctrl_o),
    .misc     (misc_o)
  );

  assign rd_acc = bus_rd & ~bus_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_acc) begin
      if (cfg_mode)      bus_rdata <= {{PAD_W{1'b0}}, cfg_byte};
      else if (bus_wide) bus_rdata <= tf_word;
      else               bus_rdata <= {{PAD_W{1'b0}}, tf_word[BYTE_W-1:0]};
    end
  end

  assign cfg_active = cfg_mode;

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_acc |=> $stable(bus_rdata));

  assert_cfg_read_narrow_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && cfg_mode) |=> bus_rdata[DATA_W-1:BYTE_W] == '0);

endmodule

// File: tb/cfg_trapdoor_window_tb_top.sv
module cfg_trapdoor_window_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_wide = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        strap_in = 1'b0;
  logic [15:0] bus_rdata;
  logic        cfg_active;
  logic [7:0]  rd_timing_o, wr_timing_o, ctrl_o, misc_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  cfg_trapdoor_window dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wide(bus_wide), .bus_wdata(bus_wdata), .strap_in(strap_in),
    .bus_rdata(bus_rdata), .cfg_active(cfg_active), .rd_timing_o(rd_timing_o),
    .wr_timing_o(wr_timing_o), .ctrl_o(ctrl_o), .misc_o(misc_o)
  );

  // bench model state
  logic [15:0] m_tf [8];
  logic [7:0]  m_rd, m_wr, m_ctrl, m_strap, m_misc;
  bit          m_mode;
  int          m_arm;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_tf[i] = '0;
    m_rd = 0; m_wr = 0; m_ctrl = 0; m_strap = 0; m_misc = 0;
    m_mode = 0; m_arm = 0;
  endtask

  function automatic logic [7:0] cfg_read(input logic [2:0] a);
    case (a)
      3'd0: return m_rd;
      3'd1: return m_wr;
      3'd3: return m_ctrl;
      3'd5: return (m_strap == 8'hFF) ? {7'b0, strap_in} : m_strap;
      3'd6: return m_misc;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd_t();
    if (m_ctrl == 8'h85) return m_rd;
    return strap_in ? 8'h48 : 8'h6C;
  endfunction

  function automatic logic [7:0] exp_wr_t();
    if (m_ctrl == 8'h85) return m_wr;
    return strap_in ? 8'h3D : 8'h5E;
  endfunction

  // one bus access, driven at a falling edge, checked at the next falling edge
  task automatic acc(input bit r, input bit w, input bit wide, input logic [2:0] a,
                     input logic [15:0] d, input string tag);
    logic [15:0] exp;
    logic [7:0]  wb;
    exp = bus_rdata;
    wb  = d[7:0];
    if (w) begin
      if (m_mode) begin
        if (!wide) begin
          if (a == 3'd2 && wb == 8'h83) m_mode = 0;
          else case (a)
            3'd0: m_rd = wb;
            3'd1: m_wr = wb;
            3'd3: m_ctrl = wb;
            3'd5: m_strap = wb;
            3'd6: m_misc = wb;
            default: ;
          endcase
        end
      end else if (!wide && a == 3'd2 && m_arm == 2 && wb == 8'h03) begin
        m_mode = 1; m_arm = 0;
      end else begin
        if (wide) m_tf[a] = d; else m_tf[a][7:0] = wb;
        m_arm = 0;
      end
    end else if (r) begin
      if (m_mode) exp = {8'h00, cfg_read(a)};
      else begin
        exp = wide ? m_tf[a] : {8'h00, m_tf[a][7:0]};
        if (wide && a == 3'd1) m_arm = (m_arm == 0) ? 1 : (m_arm == 1) ? 2 : 0;
        else m_arm = 0;
      end
    end
    bus_rd = r; bus_wr = w; bus_wide = wide; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
    if (r && !w) chk({tag, " rdata"}, bus_rdata, exp);
    chk({tag, " cfg_active"}, {15'b0, cfg_active}, {15'b0, m_mode});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_outs(input string tag);
    idle(2);
    chk({tag, " rd_timing"}, {8'h0, rd_timing_o}, {8'h0, exp_rd_t()});
    chk({tag, " wr_timing"}, {8'h0, wr_timing_o}, {8'h0, exp_wr_t()});
    chk({tag, " ctrl"}, {8'h0, ctrl_o}, {8'h0, m_ctrl});
    chk({tag, " misc"}, {8'h0, misc_o}, {8'h0, m_misc});
  endtask

  task automatic do_unlock(input string tag);
    acc(1, 0, 1, 3'd1, 16'h0, tag);
    acc(1, 0, 1, 3'd1, 16'h0, tag);
    acc(0, 1, 0, 3'd2, 16'h0003, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4242));
    model_reset();
    idle(4);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg_active", {15'b0, cfg_active}, 16'h0);
    chk("R1 rdata", bus_rdata, 16'h0);
    chk_outs("R1");

    // R10 strap selects the defaults
    strap_in = 1;
    chk_outs("R10 strap fast");
    strap_in = 0;

    // R8 locked task-file behaviour
    acc(0, 1, 1, 3'd4, 16'hBEEF, "R8 wide wr");
    acc(0, 1, 0, 3'd4, 16'h1234, "R8 byte wr");
    acc(1, 0, 1, 3'd4, 16'h0, "R8 wide rd");
    acc(1, 0, 0, 3'd4, 16'h0, "R8 byte rd");
    idle(2);
    chk("R8 rdata held", bus_rdata, 16'h0034);

    // R2 unlock with idle gaps, R11 unlock write not stored
    acc(0, 1, 1, 3'd2, 16'h5A5A, "R11 prefill");
    acc(1, 0, 1, 3'd1, 16'h0, "R2");
    idle(3);
    acc(1, 0, 1, 3'd1, 16'h0, "R2");
    idle(2);
    acc(0, 1, 0, 3'd2, 16'h0003, "R2 unlock");

    // R5 register map
    acc(0, 1, 0, 3'd0, 16'h0011, "R5");
    acc(0, 1, 0, 3'd1, 16'h0022, "R5");
    acc(0, 1, 0, 3'd3, 16'h0033, "R5");
    acc(0, 1, 0, 3'd6, 16'h0066, "R5");
    acc(0, 1, 0, 3'd4, 16'h0044, "R5");
    for (int a = 0; a < 8; a++) acc(1, 0, 1, 3'(a), 16'h0, "R5 readback");
    // R6 strap probe
    acc(0, 1, 0, 3'd5, 16'h0012, "R6");
    acc(1, 0, 0, 3'd5, 16'h0, "R6 stored");
    acc(0, 1, 0, 3'd5, 16'h00FF, "R6");
    strap_in = 1;
    acc(1, 0, 0, 3'd5, 16'h0, "R6 probe fast");
    strap_in = 0;
    acc(1, 0, 0, 3'd5, 16'h0, "R6 probe slow");
    // R7 wide writes ignored
    acc(0, 1, 1, 3'd0, 16'hAAAA, "R7");
    acc(1, 0, 0, 3'd0, 16'h0, "R7 readback");
    chk_outs("R10 before override");
    // R10 override
    acc(0, 1, 0, 3'd3, 16'h0085, "R10");
    chk_outs("R10 override");
    strap_in = 1;
    chk_outs("R10 override strap ignored");
    strap_in = 0;
    // R4 other offset-2 write ignored, then relock
    acc(0, 1, 0, 3'd2, 16'h0044, "R4 other");
    acc(1, 0, 0, 3'd0, 16'h0, "R4 bank intact");
    acc(0, 1, 0, 3'd2, 16'h0083, "R4 relock");
    // R11 task file word at offset 2 untouched by cfg traffic
    acc(1, 0, 1, 3'd2, 16'h0, "R11 tf2");
    acc(1, 0, 1, 3'd4, 16'h0, "R11 tf4");

    // R9 locked writes do not reach the bank
    acc(0, 1, 0, 3'd0, 16'h00E0, "R9");
    acc(0, 1, 0, 3'd1, 16'h00E1, "R9");
    acc(0, 1, 0, 3'd3, 16'h00E3, "R9");
    acc(0, 1, 0, 3'd5, 16'h00E5, "R9");
    acc(0, 1, 0, 3'd6, 16'h00E6, "R9");
    chk_outs("R9 outputs");
    do_unlock("R9 reunlock");
    for (int a = 0; a < 8; a++) acc(1, 0, 0, 3'(a), 16'h0, "R9 readback");
    acc(0, 1, 0, 3'd3, 16'h0000, "R10 clear");
    chk_outs("R10 defaults back");
    acc(0, 1, 0, 3'd2, 16'h0083, "R4 relock");

    // R3 broken sequences
    acc(1, 0, 1, 3'd1, 16'h0, "R3 a");
    acc(1, 0, 0, 3'd1, 16'h0, "R3 a byte rd");
    acc(1, 0, 1, 3'd1, 16'h0, "R3 a");
    acc(0, 1, 0, 3'd2, 16'h0003, "R3 a gate");
    acc(1, 0, 1, 3'd1, 16'h0, "R3 b");
    acc(1, 0, 1, 3'd3, 16'h0, "R3 b other rd");
    acc(1, 0, 1, 3'd1, 16'h0, "R3 b");
    acc(0, 1, 0, 3'd2, 16'h0003, "R3 b gate");
    acc(1, 0, 1, 3'd1, 16'h0, "R3 c");
    acc(1, 0, 1, 3'd1, 16'h0, "R3 c");
    acc(1, 0, 1, 3'd1, 16'h0, "R3 c third");
    acc(0, 1, 0, 3'd2, 16'h0003, "R3 c gate");
    acc(1, 0, 1, 3'd1, 16'h0, "R3 d");
    acc(1, 0, 1, 3'd1, 16'h0, "R3 d");
    acc(0, 1, 0, 3'd2, 16'h0004, "R3 d wrong code");
    acc(0, 1, 0, 3'd2, 16'h0003, "R3 d gate");
    // R11 non-completing 0x03 stored
    acc(1, 0, 1, 3'd2, 16'h0, "R11 stored");

    // seeded random traffic against the model (R3 R5 R8)
    for (int i = 0; i < 600; i++) begin
      int k;
      logic [2:0]  a;
      logic [15:0] d;
      k = int'($urandom % 10);
      a = 3'($urandom % 8);
      d = 16'($urandom);
      if (k == 9 && ($urandom % 2) == 0) d[7:0] = m_mode ? 8'h83 : 8'h03;
      case (k)
        0, 1:    acc(1, 0, 1, a, d, "RAND R8");
        2:       acc(1, 0, 1, 3'd1, d, "RAND R3");
        3:       acc(1, 0, 0, a, d, "RAND R8");
        4, 5:    acc(0, 1, 0, a, d, "RAND R5");
        6:       acc(0, 1, 1, a, d, "RAND R7");
        7:       if (!m_mode) do_unlock("RAND R2"); else idle(1);
        8:       idle(1);
        default: acc(0, 1, 0, 3'd2, d, "RAND R4");
      endcase
    end
    chk_outs("RAND R10");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule